// File: doc/BRIEF.md
# Dual-Compare Timer Output Controller

An 8-bit up-counter is compared every cycle against two programmable constants. When the counter is counting and equals a constant, a match event occurs on that channel. Each channel carries a two-bit action code that says what the match does to one shared timer output: nothing, force low, force high, or invert. When both channels match in the same cycle, the stronger action wins: invert beats force high, which beats force low. A channel whose code is "nothing" takes no part in this contest.

All four action bits at zero disable the pin. A separate control bit lets a channel-A match emit a one-cycle strobe that starts an external analog-to-digital conversion. Software reaches the counter, both constants and the control register through a small synchronous write port with a combinational read-back. A count-enable input advances the counter.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, tmr_o, tmr_oe_o and adc_trig_o are 0, the counter and the control register read 0x00, and both constants read 0xFF.
- R2: The register map is: address 0 = counter, 1 = constant A, 2 = constant B, 3 = control. A write takes effect at the clock edge where wr_en_i is high. rdata_o shows the addressed register combinationally. Control bits [7:5] read as 0.
- R3: The counter adds 1 at each edge where cnt_en_i is high and wraps from 0xFF to 0x00. It holds when cnt_en_i is low. A counter write in the same cycle as cnt_en_i wins over the increment.
- R4: A channel matches only in a cycle where cnt_en_i is high and the counter equals that channel's constant. The output level changes at the edge that ends the match cycle and at no other time.
- R5: Control bits [1:0] hold the action for channel A and bits [3:2] the action for channel B. Codes: 00 = no change, 01 = drive 0, 10 = drive 1, 11 = invert the current level.
- R6: When both channels match in one cycle, invert takes precedence over drive 1, and drive 1 takes precedence over drive 0. A channel with code 00 is ignored, so the other channel's action applies alone.
- R7: When control bits [3:0] are all 0, tmr_oe_o is 0 and tmr_o is 0. Otherwise tmr_oe_o is 1 and tmr_o shows the output level.
- R8: When control bit 4 is 1, a channel-A match drives adc_trig_o high for exactly the cycle after the match. When bit 4 is 0, adc_trig_o stays 0.
- R9: After reset, the output level stays 0 until the first match event, even when the output is enabled and the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| cnt_en_i | input | 1 | Counter enable |
| tmr_o | output | 1 | Timer output level |
| tmr_oe_o | output | 1 | Timer output enabled |
| adc_trig_o | output | 1 | One-cycle conversion start strobe |

## Verification
The bench covers every pair of action codes, with the ADC enable bit both set and clear. For each pair it runs four cases: no match, A alone, B alone, and both channels together. Each case starts from both output levels, which the bench sets beforehand with a forcing match. A resolver with the wrong precedence would leave the pin high where an invert should have dropped it. A resolver that let a 00 channel block its partner would freeze the pin. Further runs check the strobe in the cycle after the match and in the cycle after that. A strobe that stretched, or that fired on a B match or with the enable bit clear, shows up at the port. Directed runs also cover the counter wrap, a write landing together with an increment, a counter parked on a constant with counting stopped (which must not match), and the pin staying low after reset until the first match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  typedef struct packed {
    logic adc_en;
    act_e act_b;
    act_e act_a;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned NCH    = 2;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [CNT_W-1:0]           wdata_i,
  output logic [CNT_W-1:0]           rdata_o,
  input  logic                       cnt_en_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [NCH-1:0][CNT_W-1:0]  cmp_o,
  output ctrl_t                      ctrl_o
);
  localparam logic [CNT_W-1:0] CMP_RST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [NCH-1:0][CNT_W-1:0] cmp_q;
  ctrl_t ctrl_q;
  logic wr_cnt, wr_ctrl;
  logic [NCH-1:0] wr_cmp;
  logic chk_live_q;
  logic ctrl_unused;

  assign ctrl_unused = ^wdata_i[CNT_W-1:CTRL_W];

  assign wr_cnt  = wr_en_i && (addr_i == ADDR_CNT);
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_cmp[0] = wr_en_i && (addr_i == ADDR_CMPA);
  assign wr_cmp[1] = wr_en_i && (addr_i == ADDR_CMPB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_cnt)   cnt_q <= wdata_i;
    else if (cnt_en_i) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cmp_q[g] <= CMP_RST;
      else if (wr_cmp[g]) cmp_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CNT:  rdata_o = cnt_q;
      ADDR_CMPA: rdata_o = cmp_q[0];
      ADDR_CMPB: rdata_o = cmp_q[1];
      default:   rdata_o = CNT_W'(ctrl_q);
    endcase
  end

  assign cnt_o  = cnt_q;
  assign cmp_o  = cmp_q;
  assign ctrl_o = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_live_q <= 1'b0;
    else         chk_live_q <= 1'b1;
  end

  // R3
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_live_q && $past(cnt_en_i && !wr_cnt) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_live_q && $past(!cnt_en_i && !wr_cnt) |-> $stable(cnt_q));
  // R2
  cnt_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_live_q && $past(wr_cnt) |-> cnt_q == $past(wdata_i));
endmodule

// File: rtl/tmr_match.sv
module tmr_match
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic                      cnt_en_i,
  input  logic [NCH-1:0][CNT_W-1:0] cmp_i,
  output logic [NCH-1:0]            match_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign match_o[g] = cnt_en_i && (cnt_i == cmp_i[g]);
  end
endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl
  import tmr_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] match_i,
  input  ctrl_t          ctrl_i,
  output logic           tmr_o,
  output logic           tmr_oe_o,
  output logic           adc_trig_o
);
  act_e act [NCH];
  logic any_tgl, any_set, any_clr;
  logic level_q, level_d;
  logic adc_q;
  logic chk_live_q;

  assign act[0] = ctrl_i.act_a;
  assign act[1] = ctrl_i.act_b;

  always_comb begin
    any_tgl = 1'b0;
    any_set = 1'b0;
    any_clr = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (match_i[i]) begin
        any_tgl = any_tgl | (act[i] == ACT_TGL);
        any_set = any_set | (act[i] == ACT_SET);
        any_clr = any_clr | (act[i] == ACT_CLR);
      end
    end
  end

  // invert > drive 1 > drive 0
  always_comb begin
    if (any_tgl)      level_d = ~level_q;
    else if (any_set) level_d = 1'b1;
    else if (any_clr) level_d = 1'b0;
    else              level_d = level_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      adc_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      adc_q   <= match_i[0] && ctrl_i.adc_en;
    end
  end

  assign tmr_oe_o   = (ctrl_i.act_a != ACT_NONE) || (ctrl_i.act_b != ACT_NONE);
  assign tmr_o      = tmr_oe_o && level_q;
  assign adc_trig_o = adc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_live_q <= 1'b0;
    else         chk_live_q <= 1'b1;
  end

  // R4
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_live_q && $past(match_i == '0) |-> $stable(level_q));
  // R6
  tgl_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_live_q && $past((match_i[0] && ctrl_i.act_a == ACT_TGL) ||
                        (match_i[1] && ctrl_i.act_b == ACT_TGL))
    |-> level_q != $past(level_q));
  // R8
  adc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_live_q && adc_trig_o |-> $past(ctrl_i.adc_en && match_i[0]));
  // R7
  out_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.act_a == ACT_NONE && ctrl_i.act_b == ACT_NONE) |-> !tmr_o && !tmr_oe_o);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              cnt_en_i,
  output logic              tmr_o,
  output logic              tmr_oe_o,
  output logic              adc_trig_o
);
  logic [CNT_W-1:0]          cnt;
  logic [NCH-1:0][CNT_W-1:0] cmp;
  ctrl_t                     ctrl;
  logic [NCH-1:0]            match;

  tmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .cnt_en_i (cnt_en_i),
    .cnt_o    (cnt),
    .cmp_o    (cmp),
    .ctrl_o   (ctrl)
  );

  tmr_match #(.CNT_W(CNT_W)) match_i (
    .cnt_i    (cnt),
    .cnt_en_i (cnt_en_i),
    .cmp_i    (cmp),
    .match_o  (match)
  );

  tmr_out_ctl out_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .match_i    (match),
    .ctrl_i     (ctrl),
    .tmr_o      (tmr_o),
    .tmr_oe_o   (tmr_oe_o),
    .adc_trig_o (adc_trig_o)
  );
endmodule

// File: tb/dual_cmp_timer_tb_top.sv
module dual_cmp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       cnt_en = 1'b0;
  logic       tmr, tmr_oe, adc_trig;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dual_cmp_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cnt_en_i(cnt_en), .tmr_o(tmr), .tmr_oe_o(tmr_oe),
    .adc_trig_o(adc_trig)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, $sformatf("read addr %0d", a), int'(rdata), int'(exp));
  endtask

  task automatic run(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  function automatic logic next_lvl(input logic lvl, input logic [1:0] ea, input logic [1:0] eb);
    if (ea == 2'b11 || eb == 2'b11) return ~lvl;
    if (ea == 2'b10 || eb == 2'b10) return 1'b1;
    if (ea == 2'b01 || eb == 2'b01) return 1'b0;
    return lvl;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "tmr_o", int'(tmr), 0);
    chk("R1", "tmr_oe_o", int'(tmr_oe), 0);
    chk("R1", "adc_trig_o", int'(adc_trig), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1", 2'd0, 8'h00);
    rd_chk("R1", 2'd1, 8'hFF);
    rd_chk("R1", 2'd2, 8'hFF);
    rd_chk("R1", 2'd3, 8'h00);

    // R2 write and read back, control upper bits read zero
    wr(2'd1, 8'h5A);
    rd_chk("R2", 2'd1, 8'h5A);
    wr(2'd2, 8'hA5);
    rd_chk("R2", 2'd2, 8'hA5);
    wr(2'd3, 8'hE0);
    rd_chk("R2", 2'd3, 8'h00);
    chk("R7", "oe with no actions", int'(tmr_oe), 0);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);

    // R9 invert on A enabled, counter runs without reaching A
    wr(2'd3, 8'h03);
    run(20);
    chk("R9", "tmr_o before first match", int'(tmr), 0);
    chk("R7", "oe with A active", int'(tmr_oe), 1);
    rd_chk("R3", 2'd0, 8'd20);

    // R4 match only when counter reaches constant while counting
    wr(2'd1, 8'd30);
    run(10);
    chk("R4", "tmr_o before match", int'(tmr), 0);
    run(1);
    chk("R4", "tmr_o after match", int'(tmr), 1);
    wr(2'd0, 8'd30);
    repeat (3) @(negedge clk);
    chk("R4", "no match with counting stopped", int'(tmr), 1);

    // R3 wrap and hold
    wr(2'd0, 8'hFE);
    run(3);
    rd_chk("R3", 2'd0, 8'h01);
    repeat (4) @(negedge clk);
    rd_chk("R3", 2'd0, 8'h01);
    // R3 write wins over increment
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h40; cnt_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_en = 1'b0;
    rd_chk("R3", 2'd0, 8'h40);

    // R5 R6 R7 R8 sweep: codes, scenarios, starting levels, adc enable
    for (int ca = 0; ca < 4; ca++) begin
      for (int cb = 0; cb < 4; cb++) begin
        for (int sc = 0; sc < 4; sc++) begin
          for (int il = 0; il < 2; il++) begin
            for (int ae = 0; ae < 2; ae++) begin
              logic lvl, oe_e, adc_e;
              logic [1:0] ea, eb;
              logic [7:0] cw;
              // force a known level through a channel A match
              wr(2'd3, (il != 0) ? 8'h02 : 8'h01);
              wr(2'd1, 8'd10);
              wr(2'd0, 8'd10);
              run(1);
              lvl = 1'(il);
              chk("R5", "primed level", int'(tmr), int'(lvl));
              wr(2'd1, sc[0] ? 8'd20 : 8'd30);
              wr(2'd2, sc[1] ? 8'd20 : 8'd30);
              wr(2'd0, 8'd20);
              cw = {3'b000, 1'(ae), 2'(cb), 2'(ca)};
              wr(2'd3, cw);
              run(1);
              ea = sc[0] ? 2'(ca) : 2'b00;
              eb = sc[1] ? 2'(cb) : 2'b00;
              lvl = next_lvl(lvl, ea, eb);
              oe_e = (ca != 0) || (cb != 0);
              adc_e = sc[0] && (ae != 0);
              chk("R6", $sformatf("tmr_o a=%0d b=%0d sc=%0d il=%0d", ca, cb, sc, il),
                  int'(tmr), int'(oe_e && lvl));
              chk("R7", "tmr_oe_o", int'(tmr_oe), int'(oe_e));
              chk("R8", "adc pulse", int'(adc_trig), int'(adc_e));
              @(negedge clk);
              chk("R8", "adc pulse ended", int'(adc_trig), 0);
            end
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule